// File: doc/BRIEF.md
# Eight-Bit ALU with Registered Carry and Zero Flags

This block is the arithmetic and logic unit of a small 8-bit datapath. Two operands enter it: `a_i`, the destination register value, and `b_i`, the source register, immediate or load value. A 3-bit operation code selects one of eight functions: add, add with carry, subtract, subtract with borrow, AND, OR, XOR, or a pass of `b_i` that serves immediates and memory loads. The result and the next values of both flags come straight out of combinational logic.

A carry flag and a zero flag live in two flip-flops inside the block. Add with carry and subtract with borrow read the stored carry. For subtraction the carry flag holds a borrow. The flags take their next values on a rising clock edge only when `flag_we_i` is high. An active-low asynchronous reset clears both flags. Operand selection and the register file sit outside the block.

Top module: `flag_alu`

## Requirements
- R1: With `op_i` = 3'b000 (add), `res_o` = (`a_i` + `b_i`) mod 256 and `carry_nxt_o` is the carry out of bit 7.
- R2: With `op_i` = 3'b001 (add with carry), `res_o` = (`a_i` + `b_i` + stored carry) mod 256 and `carry_nxt_o` is the carry out of bit 7.
- R3: With `op_i` = 3'b010 (subtract), `res_o` = (`a_i` − `b_i`) mod 256 and `carry_nxt_o` is 1 exactly when `b_i` > `a_i` as unsigned numbers.
- R4: With `op_i` = 3'b011 (subtract with borrow), `res_o` = (`a_i` − `b_i` − stored carry) mod 256 and `carry_nxt_o` is 1 exactly when `b_i` + stored carry > `a_i`.
- R5: With `op_i` = 3'b100 (AND) or 3'b101 (OR), `res_o` is the bitwise AND or OR of the operands and `carry_nxt_o` is 0.
- R6: With `op_i` = 3'b110 (XOR), `res_o` is the bitwise XOR of the operands and `carry_nxt_o` is 1.
- R7: For every `op_i` from 3'b000 to 3'b110, `zero_nxt_o` is 1 exactly when `res_o` is 8'h00.
- R8: With `op_i` = 3'b111 (pass), `res_o` = `b_i`, and `carry_nxt_o` and `zero_nxt_o` equal the stored flags, so a load with `flag_we_i` high leaves both flags unchanged.
- R9: `carry_o` and `zero_o` take the values of `carry_nxt_o` and `zero_nxt_o` on a rising clock edge while `flag_we_i` is 1. While `flag_we_i` is 0 they hold.
- R10: While `rst_n` is low, both stored flags are 0, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags load on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears both flags |
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand (source register, immediate or load data) |
| op_i | input | 3 | Operation code, encoded as listed in R1 to R8 |
| flag_we_i | input | 1 | Flag update enable |
| res_o | output | 8 | Combinational result |
| carry_nxt_o | output | 1 | Combinational next carry/borrow flag |
| zero_nxt_o | output | 1 | Combinational next zero flag |
| carry_o | output | 1 | Stored carry/borrow flag |
| zero_o | output | 1 | Stored zero flag |

## Verification
`res_o`, `carry_nxt_o` and `zero_nxt_o` are due in the same cycle as the operands, so the bench drives each vector just after a falling edge and samples these outputs 1 ns later, before any rising edge. `carry_o` and `zero_o` are due one rising edge after a cycle in which `flag_we_i` is high, so the bench reads them at the falling edge that follows that rising edge. Add with carry and subtract with borrow depend on the stored carry. Before each such vector the bench therefore runs a one-cycle XOR or AND to set or clear the carry. The directed tests check that the flags hold when the enable is low, hold through a pass, and clear when reset is asserted between clock edges.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_ADC  = 3'b001,
        OP_SUB  = 3'b010,
        OP_SBC  = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_PASS = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } flags_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         add_cin,
    input  logic         sub_bin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic [W-1:0] diff,
    output logic         bout
);
    localparam int WX = W + 1;

    logic [WX-1:0] sum_x;
    logic [WX-1:0] diff_x;

    always_comb begin
        sum_x  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, add_cin};
        diff_x = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, sub_bin};
        sum    = sum_x[W-1:0];
        cout   = sum_x[W];
        diff   = diff_x[W-1:0];
        bout   = diff_x[W];
    end

    // R3
    always_comb begin
        if (!$isunknown({a, b, sub_bin}) && !sub_bin) begin
            sub_borrow_chk: assert (bout == (b > a));
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_r,
    output logic [W-1:0] or_r,
    output logic [W-1:0] xor_r
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_r[i] = a[i] & b[i];
        assign or_r[i]  = a[i] | b[i];
        assign xor_r[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import flag_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  flags_t nxt,
    output flags_t cur
);
    flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (we) begin
            flags_d = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign cur = flags_q;

    // R10
    reset_clears_flags_chk: assert property (@(posedge clk)
        !rst_n |-> (flags_q == '0));

    // R9
    hold_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flags_q));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   op_i,
    input  logic         flag_we_i,
    output logic [W-1:0] res_o,
    output logic         carry_nxt_o,
    output logic         zero_nxt_o,
    output logic         carry_o,
    output logic         zero_o
);
    typedef struct packed {
        logic [W-1:0] res;
        flags_t       fl;
    } alu_out_t;

    alu_op_e      op;
    flags_t       flags_q;
    alu_out_t     out_d;
    logic [W-1:0] sum, diff, and_r, or_r, xor_r;
    logic         cout, bout;
    logic         add_cin, sub_bin;

    assign op      = alu_op_e'(op_i);
    assign add_cin = (op == OP_ADC) & flags_q.carry;
    assign sub_bin = (op == OP_SBC) & flags_q.carry;

    alu_arith #(.W(W)) u_arith (
        .a       (a_i),
        .b       (b_i),
        .add_cin (add_cin),
        .sub_bin (sub_bin),
        .sum     (sum),
        .cout    (cout),
        .diff    (diff),
        .bout    (bout)
    );

    alu_logic #(.W(W)) u_logic (
        .a     (a_i),
        .b     (b_i),
        .and_r (and_r),
        .or_r  (or_r),
        .xor_r (xor_r)
    );

    always_comb begin
        out_d.res      = b_i;
        out_d.fl.carry = flags_q.carry;
        unique case (op)
            OP_ADD, OP_ADC: begin
                out_d.res      = sum;
                out_d.fl.carry = cout;
            end
            OP_SUB, OP_SBC: begin
                out_d.res      = diff;
                out_d.fl.carry = bout;
            end
            OP_AND: begin
                out_d.res      = and_r;
                out_d.fl.carry = 1'b0;
            end
            OP_OR: begin
                out_d.res      = or_r;
                out_d.fl.carry = 1'b0;
            end
            OP_XOR: begin
                out_d.res      = xor_r;
                out_d.fl.carry = 1'b1;
            end
            default: begin
                out_d.res      = b_i;
                out_d.fl.carry = flags_q.carry;
            end
        endcase
        out_d.fl.zero = (op == OP_PASS) ? flags_q.zero : (out_d.res == '0);
    end

    alu_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we_i),
        .nxt   (out_d.fl),
        .cur   (flags_q)
    );

    assign res_o       = out_d.res;
    assign carry_nxt_o = out_d.fl.carry;
    assign zero_nxt_o  = out_d.fl.zero;
    assign carry_o     = flags_q.carry;
    assign zero_o      = flags_q.zero;

    // R5
    logic_clears_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && (op_i == 3'b100 || op_i == 3'b101)) |=> !carry_o);

    // R6
    xor_sets_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i == 3'b110) |=> carry_o);

    // R7
    zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i != 3'b111) |=> (zero_o == ($past(res_o) == '0)));

    // R8
    pass_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i == 3'b111) |=> ($stable(carry_o) && $stable(zero_o)));

    // R8
    pass_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b111) |-> (res_o == b_i));

endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

    logic       clk;
    logic       rst_n;
    logic [7:0] a, b, res;
    logic [2:0] op;
    logic       we;
    logic       cn, zn, cq, zq;

    int checks = 0;
    int fails  = 0;

    flag_alu u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_i         (a),
        .b_i         (b),
        .op_i        (op),
        .flag_we_i   (we),
        .res_o       (res),
        .carry_nxt_o (cn),
        .zero_nxt_o  (zn),
        .carry_o     (cq),
        .zero_o      (zq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // {pre_carry, op, a, b, exp_res, exp_carry, exp_zero}
    localparam int NV = 18;
    localparam logic [29:0] VECS [0:NV-1] = '{
        {1'b0, 3'b000, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0},  // R1
        {1'b0, 3'b000, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},  // R1
        {1'b0, 3'b000, 8'hC8, 8'h64, 8'h2C, 1'b1, 1'b0},  // R1
        {1'b1, 3'b001, 8'h10, 8'h20, 8'h31, 1'b0, 1'b0},  // R2
        {1'b1, 3'b001, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1},  // R2
        {1'b0, 3'b001, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b0},  // R2
        {1'b0, 3'b010, 8'h50, 8'h20, 8'h30, 1'b0, 1'b0},  // R3
        {1'b0, 3'b010, 8'h20, 8'h50, 8'hD0, 1'b1, 1'b0},  // R3
        {1'b1, 3'b010, 8'h42, 8'h42, 8'h00, 1'b0, 1'b1},  // R3
        {1'b1, 3'b011, 8'h42, 8'h41, 8'h00, 1'b0, 1'b1},  // R4
        {1'b1, 3'b011, 8'h42, 8'h42, 8'hFF, 1'b1, 1'b0},  // R4
        {1'b0, 3'b011, 8'h10, 8'h01, 8'h0F, 1'b0, 1'b0},  // R4
        {1'b1, 3'b100, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},  // R5
        {1'b1, 3'b100, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b1},  // R5
        {1'b1, 3'b101, 8'hA0, 8'h05, 8'hA5, 1'b0, 1'b0},  // R5
        {1'b1, 3'b101, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1},  // R5
        {1'b0, 3'b110, 8'h5A, 8'hFF, 8'hA5, 1'b1, 1'b0},  // R6
        {1'b0, 3'b110, 8'h33, 8'h33, 8'h00, 1'b1, 1'b1}   // R6
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive at falling edge, outputs sampled 1 ns later
    task automatic drive(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y, input logic w);
        @(negedge clk);
        op = o; a = x; b = y; we = w;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // set stored carry: XOR sets it (R6), AND clears it (R5)
    task automatic set_carry(input logic c);
        if (c) drive(3'b110, 8'h01, 8'h00, 1'b1);
        else   drive(3'b100, 8'h00, 8'h00, 1'b1);
        tick();
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b1; op = 3'b000; a = '0; b = '0; we = 1'b0;
        #3 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset carry", {7'd0, cq}, 8'd0);
        chk("R10 reset zero",  {7'd0, zq}, 8'd0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            string tg;
            v = VECS[i];
            tg = $sformatf("R%0d vec%0d", (v[28:26] < 3'd4) ? (v[28:26] / 3'd2) * 2 + 1 + (v[26] & 1'b0) : 5, i);
            set_carry(v[29]);
            drive(v[28:26], v[25:18], v[17:10], 1'b1);
            chk({"R1-7 res ", tg}, res, v[9:2]);
            chk({"R1-6 carry_nxt ", tg}, {7'd0, cn}, {7'd0, v[1]});
            chk({"R7 zero_nxt ", tg}, {7'd0, zn}, {7'd0, v[0]});
            tick();
            chk({"R9 carry_q ", tg}, {7'd0, cq}, {7'd0, v[1]});
            chk({"R9 zero_q ", tg},  {7'd0, zq}, {7'd0, v[0]});
        end

        // R8: pass keeps flags (set carry=1, zero=0 first)
        drive(3'b110, 8'h01, 8'h00, 1'b1);
        tick();
        drive(3'b111, 8'h55, 8'h00, 1'b1);
        chk("R8 pass res zero-valued b", res, 8'h00);
        chk("R8 pass zero_nxt kept", {7'd0, zn}, 8'd0);
        chk("R8 pass carry_nxt kept", {7'd0, cn}, 8'd1);
        tick();
        chk("R8 pass carry_q kept", {7'd0, cq}, 8'd1);
        chk("R8 pass zero_q kept",  {7'd0, zq}, 8'd0);
        drive(3'b111, 8'h00, 8'h9C, 1'b1);
        chk("R8 pass res", res, 8'h9C);
        tick();
        chk("R8 pass carry_q kept 2", {7'd0, cq}, 8'd1);

        // R9: enable low holds flags (carry=0, zero=0 first)
        drive(3'b100, 8'hFF, 8'h01, 1'b1);
        tick();
        drive(3'b000, 8'hFF, 8'h01, 1'b0);
        chk("R9 nxt carry with we low", {7'd0, cn}, 8'd1);
        chk("R9 nxt zero with we low",  {7'd0, zn}, 8'd1);
        tick();
        chk("R9 carry held", {7'd0, cq}, 8'd0);
        chk("R9 zero held",  {7'd0, zq}, 8'd0);

        // R2/R4 with stored carry observed after hold: add with carry uses stored 0
        drive(3'b001, 8'h01, 8'h01, 1'b0);
        chk("R2 adc uses stored 0", res, 8'h02);

        // R10: async reset between edges
        drive(3'b110, 8'h00, 8'h00, 1'b1);
        tick();
        chk("R6 xor setup carry", {7'd0, cq}, 8'd1);
        chk("R7 xor setup zero",  {7'd0, zq}, 8'd1);
        we = 1'b0;
        #1 rst_n = 1'b0;
        #1;
        chk("R10 async carry clear", {7'd0, cq}, 8'd0);
        chk("R10 async zero clear",  {7'd0, zq}, 8'd0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R10 stays clear", {6'd0, cq, zq}, 8'd0);

        report();
    end

endmodule